// File: doc/BRIEF.md
# Selected-Mapping Peak-Power Candidate Selector

This block reduces the peak-to-average power ratio of a 64-sample time-domain OFDM symbol by selected mapping. Only one IFFT runs upstream. The block stores that IFFT output and derives three more candidate symbols from it. Each derived candidate equals the original with a period-4 phase pattern applied across the subcarriers. The block computes that product directly in the time domain. Each sample of a candidate is a weighted sum of the stored symbol read at offsets 0, 16, 32 and 48, taken circularly. Every weight is a multiple of ±1 or ±j scaled by one half, so the datapath uses only adders, negations and shifts.

The block scans all four candidates together over one pass and keeps the largest instantaneous power of each. It then streams out the candidate whose peak is smallest, together with a 2-bit index that tells the receiver which rotation was applied. The block has a single symbol buffer. It accepts input only while filling that buffer and produces output only after the selection is made.

Both streams use valid/ready handshakes. A sample moves on any rising edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the output data, index and last flag stay unchanged. `in_ready` stays low for the whole time the block is scanning, picking and sending.

Top module: `slm_selector`

## Requirements
- R1: `in_ready` is high only while the buffer is filling. Exactly 64 accepted samples make one symbol. `out_valid` stays low until all 64 samples of a symbol have been accepted. Input offered while `in_ready` is low is not stored and has no effect on the output.
- R2: Candidate 0 (index 0) is the stored symbol unchanged.
- R3: Candidate 1 (index 1, pattern 1,j,1,j) is y[n] = ((1+j)·x[n] + (1−j)·x[(n+32) mod 64]) / 2.
- R4: Candidate 2 (index 2, pattern 1,j,1,−j) is y[n] = (x[n] − x[(n+48) mod 64] + x[(n+32) mod 64] + x[(n+16) mod 64]) / 2.
- R5: Candidate 3 (index 3, pattern 1,j,−1,j) is y[n] = (j·x[n] + x[(n+48) mod 64] − j·x[(n+32) mod 64] + x[(n+16) mod 64]) / 2.
- R6: Each candidate output component is formed as follows. The full-precision sum s is computed with two guard bits. The result is floor((s+1)/2), clamped to the range −32768..32767.
- R7: The peak metric of each candidate is the maximum of I²+Q² over its 64 rounded samples. The block outputs the candidate with the smallest metric. `out_idx` carries that candidate's number, 0 to 3.
- R8: When two or more candidates share the smallest peak, the block picks the lowest index.
- R9: Each symbol produces 64 output samples in order n = 0..63. `out_last` is high only on sample 63. Under back-pressure the data, index and last flag are held. `out_idx` stays constant for the whole symbol.
- R10: The first output sample is valid 65 clock cycles after the edge that accepts the last input sample. `in_ready` is high in the cycle after the last output handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts an input sample |
| in_re | input | 16 | Input sample, real part, two's-complement fraction |
| in_im | input | 16 | Input sample, imaginary part |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Sink accepts the output sample |
| out_re | output | 16 | Selected candidate sample, real part |
| out_im | output | 16 | Selected candidate sample, imaginary part |
| out_idx | output | 2 | Number of the rotation applied to this symbol |
| out_last | output | 1 | High on the final sample of the symbol |

## Verification
The assertions check several rules on every cycle. Output is held while stalled, and the index stays fixed through a symbol. No output starts before a full symbol has been counted in. Peak trackers never decrease while they scan. The chosen candidate's peak is never above any other candidate's peak. Only the bench scenarios can show that the candidate arithmetic is correct. They also cover rounding and saturation at full-scale inputs, the exact choice among tied peaks, the 65-cycle latency, and the fact that input offered while the block is busy is ignored. The bench compares every output sample against a model computed from the candidate formulas.

// File: rtl/slm_pkg.sv
package slm_pkg;

  localparam int NCAND = 4;
  localparam int NTAP  = 4;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_SCAN = 2'd1,
    ST_PICK = 2'd2,
    ST_SEND = 2'd3
  } slm_state_e;

  // Doubled complex weights: candidate c, tap t reads x[(n + t*N/4) mod N].
  // Real part of the weight.
  localparam int WRE [NCAND][NTAP] = '{
    '{2, 0, 0,  0},
    '{1, 0, 1,  0},
    '{1, 1, 1, -1},
    '{0, 1, 0,  1}
  };
  // Imaginary part of the weight.
  localparam int WIM [NCAND][NTAP] = '{
    '{0, 0,  0, 0},
    '{1, 0, -1, 0},
    '{0, 0,  0, 0},
    '{1, 0, -1, 0}
  };

endpackage

// File: rtl/slm_sym_buf.sv
module slm_sym_buf #(
  parameter int N  = 64,
  parameter int W  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic signed [W-1:0] wr_re,
  input  logic signed [W-1:0] wr_im,
  input  logic [AW-1:0]       rd_base,
  output logic signed [W-1:0] tap_re [slm_pkg::NTAP],
  output logic signed [W-1:0] tap_im [slm_pkg::NTAP]
);

  localparam int QSTEP = N / slm_pkg::NTAP;

  logic signed [W-1:0] mem_re [N];
  logic signed [W-1:0] mem_im [N];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_re[wr_addr] <= wr_re;
      mem_im[wr_addr] <= wr_im;
    end
  end

  // Circular reads at quarter-symbol offsets; address wraps in AW bits.
  for (genvar t = 0; t < slm_pkg::NTAP; t++) begin : g_tap
    logic [AW-1:0] addr;
    assign addr      = rd_base + AW'(t * QSTEP);
    assign tap_re[t] = mem_re[addr];
    assign tap_im[t] = mem_im[addr];
  end

endmodule

// File: rtl/slm_cand_gen.sv
module slm_cand_gen
  import slm_pkg::*;
#(
  parameter int W     = 16,
  parameter int GUARD = 2
) (
  input  logic signed [W-1:0] tap_re  [NTAP],
  input  logic signed [W-1:0] tap_im  [NTAP],
  output logic signed [W-1:0] cand_re [NCAND],
  output logic signed [W-1:0] cand_im [NCAND]
);

  // Guard bits plus one bit of headroom for the rounding increment.
  localparam int SW = W + GUARD + 1;
  localparam logic signed [SW-1:0] ONE = SW'(1);
  localparam logic signed [SW-1:0] HI  = SW'((1 << (W - 1)) - 1);
  localparam logic signed [SW-1:0] LO  = ~HI;

  // Weight of 0, +-1 or +-2 applied by negation and shift only.
  function automatic logic signed [SW-1:0] wscale(input logic signed [W-1:0] x, input int w);
    logic signed [SW-1:0] e;
    e = SW'(x);
    case (w)
      2:       return e <<< 1;
      1:       return e;
      -1:      return -e;
      -2:      return -(e <<< 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [W-1:0] halve_sat(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] h;
    h = (s + ONE) >>> 1;
    if (h > HI)      return HI[W-1:0];
    else if (h < LO) return LO[W-1:0];
    else             return h[W-1:0];
  endfunction

  for (genvar c = 0; c < NCAND; c++) begin : g_cand
    logic signed [SW-1:0] acc_r;
    logic signed [SW-1:0] acc_i;

    always_comb begin
      acc_r = '0;
      acc_i = '0;
      for (int t = 0; t < NTAP; t++) begin
        acc_r = acc_r + wscale(tap_re[t], WRE[c][t]) - wscale(tap_im[t], WIM[c][t]);
        acc_i = acc_i + wscale(tap_im[t], WRE[c][t]) + wscale(tap_re[t], WIM[c][t]);
      end
    end

    assign cand_re[c] = halve_sat(acc_r);
    assign cand_im[c] = halve_sat(acc_i);
  end

endmodule

// File: rtl/slm_peak_track.sv
module slm_peak_track #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] re,
  input  logic signed [W-1:0] im,
  output logic [2*W:0]        peak
);

  logic signed [2*W-1:0] sq_r;
  logic signed [2*W-1:0] sq_i;
  logic [2*W:0]          pw;

  assign sq_r = re * re;
  assign sq_i = im * im;
  assign pw   = {1'b0, sq_r} + {1'b0, sq_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 peak <= '0;
    else if (clr)               peak <= '0;
    else if (en && pw > peak)   peak <= pw;
  end

  // R7: a scanning tracker never loses its running maximum.
  a_r7_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> peak >= $past(peak));

  // R7: after a scan step the held peak covers the power just seen.
  a_r7_peak_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> peak >= $past(pw));

endmodule

// File: rtl/slm_min_pick.sv
module slm_min_pick #(
  parameter int NC = 4,
  parameter int PW = 33,
  parameter int IW = $clog2(NC)
) (
  input  logic [PW-1:0] peaks [NC],
  output logic [IW-1:0] idx
);

  logic [PW-1:0] best;

  // Strict comparison keeps the lowest index on equal peaks.
  always_comb begin
    best = peaks[0];
    idx  = '0;
    for (int i = 1; i < NC; i++) begin
      if (peaks[i] < best) begin
        best = peaks[i];
        idx  = IW'(i);
      end
    end
  end

endmodule

// File: rtl/slm_selector.sv
module slm_selector
  import slm_pkg::*;
#(
  parameter int SYM_LEN = 64,
  parameter int SAMP_W  = 16,
  parameter int GUARD   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [SAMP_W-1:0] in_re,
  input  logic signed [SAMP_W-1:0] in_im,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [SAMP_W-1:0] out_re,
  output logic signed [SAMP_W-1:0] out_im,
  output logic [$clog2(NCAND)-1:0] out_idx,
  output logic                     out_last
);

  localparam int AW = $clog2(SYM_LEN);
  localparam int PW = 2 * SAMP_W + 1;
  localparam int IW = $clog2(NCAND);
  localparam logic [AW-1:0] POS_END = AW'(SYM_LEN - 1);

  slm_state_e state;
  logic [AW-1:0] pos;
  logic [IW-1:0] sel_q;
  logic [IW-1:0] pick_idx;
  logic          at_end;
  logic          in_hs;
  logic          out_hs;

  logic signed [SAMP_W-1:0] tap_re  [NTAP];
  logic signed [SAMP_W-1:0] tap_im  [NTAP];
  logic signed [SAMP_W-1:0] cand_re [NCAND];
  logic signed [SAMP_W-1:0] cand_im [NCAND];
  logic [PW-1:0]            peak_q  [NCAND];

  assign at_end    = (pos == POS_END);
  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_SEND);
  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FILL;
      pos   <= '0;
      sel_q <= '0;
    end else begin
      case (state)
        ST_FILL: if (in_hs) begin
          pos <= at_end ? '0 : pos + 1'b1;
          if (at_end) state <= ST_SCAN;
        end
        ST_SCAN: begin
          pos <= at_end ? '0 : pos + 1'b1;
          if (at_end) state <= ST_PICK;
        end
        ST_PICK: begin
          sel_q <= pick_idx;
          state <= ST_SEND;
        end
        ST_SEND: if (out_hs) begin
          pos <= at_end ? '0 : pos + 1'b1;
          if (at_end) state <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  slm_sym_buf #(.N(SYM_LEN), .W(SAMP_W), .AW(AW)) i_buf (
    .clk     (clk),
    .wr_en   (in_hs),
    .wr_addr (pos),
    .wr_re   (in_re),
    .wr_im   (in_im),
    .rd_base (pos),
    .tap_re  (tap_re),
    .tap_im  (tap_im)
  );

  slm_cand_gen #(.W(SAMP_W), .GUARD(GUARD)) i_cand (
    .tap_re  (tap_re),
    .tap_im  (tap_im),
    .cand_re (cand_re),
    .cand_im (cand_im)
  );

  for (genvar g = 0; g < NCAND; g++) begin : g_trk
    slm_peak_track #(.W(SAMP_W)) i_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == ST_FILL),
      .en    (state == ST_SCAN),
      .re    (cand_re[g]),
      .im    (cand_im[g]),
      .peak  (peak_q[g])
    );
  end

  slm_min_pick #(.NC(NCAND), .PW(PW), .IW(IW)) i_pick (
    .peaks (peak_q),
    .idx   (pick_idx)
  );

  assign out_re   = cand_re[sel_q];
  assign out_im   = cand_im[sel_q];
  assign out_idx  = sel_q;
  assign out_last = out_valid && at_end;

  // Independent count of accepted samples for the current symbol.
  logic [AW:0] fill_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fill_cnt <= '0;
    else if (out_hs && out_last) fill_cnt <= '0;
    else if (in_hs)              fill_cnt <= fill_cnt + 1'b1;
  end

  a_r1_full_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> fill_cnt == (AW+1)'(SYM_LEN));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last) && $stable(out_idx));

  a_r9_idx_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |=> out_valid && $stable(out_idx));

  a_r10_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && out_last) |=> in_ready);

  for (genvar g = 0; g < NCAND; g++) begin : g_chk
    a_r8_min_chosen: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> peak_q[sel_q] <= peak_q[g]);
  end

endmodule

// File: tb/test_slm_selector.sv
module test_slm_selector;

  localparam int N = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_last;
  logic signed [15:0] in_re, in_im, out_re, out_im;
  logic [1:0] out_idx;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int unsigned rng = 32'h1357_9bdf;
  int sre [N];
  int sim [N];

  slm_selector i_slm_selector (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_re (in_re), .in_im (in_im),
    .out_valid (out_valid), .out_ready (out_ready), .out_re (out_re), .out_im (out_im),
    .out_idx (out_idx), .out_last (out_last)
  );

  task automatic adv();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
  endtask

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic int halve(input int s);
    int h;
    h = (s + 1) >>> 1;
    if (h > 32767) h = 32767;
    if (h < -32768) h = -32768;
    return h;
  endfunction

  // Candidate model written from R2..R6.
  task automatic model(input int c, input int n, output int yr, output int yi);
    int a, b, cc, d;
    a = n; b = (n + 32) % N; cc = (n + 48) % N; d = (n + 16) % N;
    case (c)
      0: begin yr = sre[a]; yi = sim[a]; end
      1: begin
        yr = halve(sre[a] - sim[a] + sre[b] + sim[b]);
        yi = halve(sre[a] + sim[a] - sre[b] + sim[b]);
      end
      2: begin
        yr = halve(sre[a] - sre[cc] + sre[b] + sre[d]);
        yi = halve(sim[a] - sim[cc] + sim[b] + sim[d]);
      end
      default: begin
        yr = halve(-sim[a] + sre[cc] + sim[b] + sre[d]);
        yi = halve(sre[a] + sim[cc] - sre[b] + sim[d]);
      end
    endcase
  endtask

  task automatic pick(output int best, output bit tie);
    longint pk [4];
    int yr, yi;
    for (int c = 0; c < 4; c++) begin
      pk[c] = 0;
      for (int n = 0; n < N; n++) begin
        model(c, n, yr, yi);
        if (longint'(yr) * yr + longint'(yi) * yi > pk[c]) pk[c] = longint'(yr) * yr + longint'(yi) * yi;
      end
    end
    best = 0;
    for (int c = 1; c < 4; c++) if (pk[c] < pk[best]) best = c;
    tie = 1'b0;
    for (int c = 0; c < 4; c++) if (c != best && pk[c] == pk[best]) tie = 1'b1;
  endtask

  // mode bit0: input gaps, bit1: output back-pressure, bit2: junk offered while busy
  task automatic run_symbol(input int mode, input string force_rq);
    int eidx, j, cyc, yr, yi, idx;
    bit tie, first, busy_ok, hs;
    string rq, irq;
    pick(eidx, tie);
    irq = tie ? "R8" : "R7";
    case (eidx)
      0: rq = "R2";
      1: rq = "R3";
      2: rq = "R4";
      default: rq = "R5";
    endcase
    if (force_rq != "") rq = force_rq;

    idx = 0;
    busy_ok = 1'b1;
    while (idx < N) begin
      @(negedge clk);
      adv();
      in_valid = (mode[0] && rng[3]) ? 1'b0 : 1'b1;
      in_re = 16'(sre[idx]);
      in_im = 16'(sim[idx]);
      if (out_valid) busy_ok = 1'b0;
      hs = in_valid && in_ready;
      if (hs) idx++;
    end

    j = 0; cyc = 0; first = 1'b1;
    while (j < N) begin
      @(negedge clk);
      cyc++;
      adv();
      out_ready = (mode[1] && rng[5]) ? 1'b0 : 1'b1;
      in_valid = mode[2] ? 1'b1 : 1'b0;
      in_re = 16'(rng[15:0]);
      in_im = 16'(rng[31:16]);
      if (in_ready) busy_ok = 1'b0;
      hs = 1'b0;
      if (out_valid) begin
        if (first) begin
          chk(cyc == 66, "R10", "first output latency", cyc, 66);
          first = 1'b0;
        end
        model(eidx, j, yr, yi);
        chk(out_re == yr, rq, $sformatf("re[%0d]", j), out_re, yr);
        chk(out_im == yi, rq, $sformatf("im[%0d]", j), out_im, yi);
        chk(out_idx == eidx, irq, "selected index", out_idx, eidx);
        chk(out_last == (j == N - 1), "R9", "last flag", out_last, j == N - 1);
        hs = out_ready;
      end
      if (cyc > 2000) begin
        chk(1'b0, "R9", "output stream stalled", j, N);
        j = N;
      end
      if (hs) j++;
    end
    chk(busy_ok, "R1", "in_ready only in fill / no output during fill", busy_ok, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b1, "R10", "in_ready after last output", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "no output after symbol", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "reset out_valid", out_valid, 0);

    // all zero: every peak ties, index 0 (R8)
    for (int n = 0; n < N; n++) begin sre[n] = 0; sim[n] = 0; end
    run_symbol(0, "");

    // constant level: all candidates equal, index 0 (R8)
    for (int n = 0; n < N; n++) begin sre[n] = 1000; sim[n] = -3000; end
    run_symbol(2, "");

    // single impulse: candidates 2 and 3 tie, index 2 (R8)
    for (int n = 0; n < N; n++) begin sre[n] = 0; sim[n] = 0; end
    sre[5] = 20000;
    run_symbol(2, "");

    // two impulses: candidates 1 and 3 tie, index 1 (R8)
    for (int n = 0; n < N; n++) begin sre[n] = 0; sim[n] = 0; end
    sre[0] = 20000; sre[16] = 20000;
    run_symbol(1, "");

    // full-scale pattern that drives sums past the 16-bit range (R6)
    for (int n = 0; n < N; n++) begin
      sre[n] = (n < 48) ? 32767 : -32768;
      sim[n] = (n < 48) ? -32768 : 32767;
    end
    run_symbol(4, "R6");

    // pseudo-random full-range symbols with all handshake mixes
    for (int s = 0; s < 6; s++) begin
      for (int n = 0; n < N; n++) begin
        adv();
        sre[n] = int'($signed(rng[15:0]));
        sim[n] = int'($signed(rng[31:16]));
      end
      run_symbol(s + 2, "");
    end

    // pseudo-random small-amplitude symbol
    for (int n = 0; n < N; n++) begin
      adv();
      sre[n] = int'($signed(rng[15:0])) >>> 4;
      sim[n] = int'($signed(rng[31:16])) >>> 4;
    end
    run_symbol(7, "");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule